// File: doc/BRIEF.md
# Three-Phase Horizontal Register Clock Generator

This block drives the horizontal transport register of a frame-transfer CCD. A fast clock that runs at six times the pixel rate divides each pixel period into six sub-slots. The block builds three overlapping transport phases and a reset-gate pulse on that grid, so that charge moves one register cell per pixel period toward the selected output amplifier.

A line-enable input starts the clocks and stops them for line blanking. While the line is stopped, the phases hold a rest pattern and the reset gate stays low. A mirror-select input picks the output at the far end of the register by exchanging the first two phase waveforms. The block samples that input only when a line starts, so a line never changes direction partway through. A per-pixel strobe, the cell index and an end-of-line flag tell downstream logic where the register stands.

The cell count per line is the sum of the dummy, black-reference, timing and active cells on both sides. With the default parameters this gives 1086 cells, indexed 0 to 1085.

Top module: `hreg_clock_gen`

## Requirements
- R1: While reset is held and after reset, ph1 is high, ph2 and ph3 are low, and rg_pulse, pix_stb, pix_idx and eol are all zero.
- R2: Line_en is sampled high at a clock edge while the block is idle. That edge starts sub-slot 0 of cell 0. Each later edge with line_en high advances the sub-slot 0,1,...,5 and then back to 0. pix_stb is high exactly in sub-slot 0 of every cell.
- R3: With normal direction, ph1 is high in sub-slots 0,1,2, ph2 is high in sub-slots 2,3,4 and ph3 is high in sub-slots 4,5,0. Charge therefore moves from ph1 to ph2 to ph3.
- R4: With mirrored direction latched, the ph1 and ph2 outputs exchange waveforms and ph3 is unchanged. This also applies to the rest pattern, which becomes ph2 high only.
- R5: At no time are all three phases high or all three low. Two phases are high only at a hand-over sub-slot (0, 2 or 4).
- R6: rg_pulse is high in sub-slot 5 of every cell and low in every other cycle.
- R7: pix_idx holds the current cell number. It steps by one at each cell boundary from 0 up to CELLS-1 and then returns to 0, where a new line starts if line_en is still high.
- R8: eol is high only during sub-slot 5 of cell CELLS-1.
- R9: An edge with line_en low makes the block idle from the next cycle. Phases go to the rest pattern, and rg_pulse, pix_stb, pix_idx and eol are 0. The next enable starts again at cell 0, sub-slot 0.
- R10: mirror is latched only at a line start: the first active cycle after idle, or the wrap from cell CELLS-1 to cell 0. A change of mirror at any other time has no effect on the phases.
- R11: A complete line contains exactly CELLS pixel strobes (1086 by default), counted up to and including the cell that raises eol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-pixel clock, six times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_en | input | 1 | High to run the transport clocks, low for blanking |
| mirror | input | 1 | 1 selects mirrored read direction, latched at line start |
| ph1 | output | 1 | Transport phase 1 |
| ph2 | output | 1 | Transport phase 2 |
| ph3 | output | 1 | Transport phase 3 |
| rg_pulse | output | 1 | Reset-gate pulse, one sub-slot per cell |
| pix_stb | output | 1 | One-cycle strobe at the start of each cell |
| pix_idx | output | 11 | Index of the current cell |
| eol | output | 1 | High during the last sub-slot of the last cell |

## Verification
Every output is decoded combinationally from the slot, cell and direction registers. Each result is therefore due in the cycle that follows the edge which sampled the stimulus. A start, a stop and a mirror latch all take effect exactly one edge after line_en or mirror is sampled. The bench changes inputs shortly after a rising edge and advances a behavioural model at the same edge. It compares every output against that model at the falling edge, so each comparison falls in the single cycle where the result is defined. A mirror toggle in mid-line, an abort in mid-line, a back-to-back line wrap and the reset-release window are all compared in this way.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int SUB_SLOTS = 6;
  localparam int SLOT_W    = $clog2(SUB_SLOTS);
  localparam int NUM_PH    = 3;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [NUM_PH-1:0] phase_vec_t;
endpackage

// File: rtl/hreg_timebase.sv
module hreg_timebase
  import hreg_pkg::*;
#(
  parameter int CELLS = 1086,
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             mirror,
  output logic             active,
  output slot_t            slot,
  output logic [PIX_W-1:0] pix,
  output logic             mir_lat,
  output logic             last_cell
);
  localparam slot_t            SLOT_LAST = slot_t'(SUB_SLOTS - 1);
  localparam logic [PIX_W-1:0] PIX_LAST  = PIX_W'(CELLS - 1);

  logic             active_n;
  slot_t            slot_n;
  logic [PIX_W-1:0] pix_n;
  logic             mir_n;
  logic             at_wrap;

  assign at_wrap   = active && (slot == SLOT_LAST) && (pix == PIX_LAST);
  assign last_cell = at_wrap;

  always_comb begin
    active_n = active;
    slot_n   = slot;
    pix_n    = pix;
    mir_n    = mir_lat;
    if (!line_en) begin
      active_n = 1'b0;
      slot_n   = '0;
      pix_n    = '0;
    end else if (!active) begin
      active_n = 1'b1;
      slot_n   = '0;
      pix_n    = '0;
      mir_n    = mirror;
    end else if (slot == SLOT_LAST) begin
      slot_n = '0;
      if (pix == PIX_LAST) begin
        pix_n = '0;
        mir_n = mirror;
      end else begin
        pix_n = pix + 1'b1;
      end
    end else begin
      slot_n = slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      slot    <= '0;
      pix     <= '0;
      mir_lat <= 1'b0;
    end else begin
      active  <= active_n;
      slot    <= slot_n;
      pix     <= pix_n;
      mir_lat <= mir_n;
    end
  end

  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_LAST);
  a_r7_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_en && slot == SLOT_LAST && pix != PIX_LAST) |=> (pix == $past(pix) + 1'b1));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> (!active && slot == '0 && pix == '0));
  a_r10_mir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_en && !at_wrap) |=> $stable(mir_lat));
endmodule

// File: rtl/hreg_phase_map.sv
module hreg_phase_map
  import hreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  slot_t      slot,
  input  logic       mir_lat,
  output phase_vec_t ph
);
  phase_vec_t wave;

  generate
    for (genvar k = 0; k < NUM_PH; k++) begin : g_wave
      localparam int OFS = 2 * k;
      logic [3:0] rel;
      assign rel = (4'(slot) + 4'(SUB_SLOTS - OFS)) % 4'(SUB_SLOTS);
      assign wave[k] = active ? (rel < 4'd3) : (k == 0);
    end
  endgenerate

  assign ph[0] = mir_lat ? wave[1] : wave[0];
  assign ph[1] = mir_lat ? wave[0] : wave[1];
  assign ph[2] = wave[2];

  a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ph) >= 1) && ($countones(ph) <= 2));
  a_r5_double_at_handover: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ph) == 2) |-> (active && slot[0] == 1'b0));
endmodule

// File: rtl/hreg_clock_gen.sv
module hreg_clock_gen
  import hreg_pkg::*;
#(
  parameter int DUMMY_CELLS  = 7,
  parameter int BLACK_CELLS  = 20,
  parameter int TIMING_CELLS = 4,
  parameter int ACTIVE_CELLS = 1024,
  localparam int CELLS = 2 * (DUMMY_CELLS + BLACK_CELLS + TIMING_CELLS) + ACTIVE_CELLS,
  localparam int PIX_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             mirror,
  output logic             ph1,
  output logic             ph2,
  output logic             ph3,
  output logic             rg_pulse,
  output logic             pix_stb,
  output logic [PIX_W-1:0] pix_idx,
  output logic             eol
);
  localparam slot_t SLOT_LAST = slot_t'(SUB_SLOTS - 1);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             active;
  slot_t            slot;
  logic [PIX_W-1:0] pix;
  logic             mir_lat;
  logic             last_cell;
  phase_vec_t       ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  hreg_timebase #(.CELLS(CELLS), .PIX_W(PIX_W)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .line_en(line_en), .mirror(mirror),
    .active(active), .slot(slot), .pix(pix), .mir_lat(mir_lat),
    .last_cell(last_cell)
  );

  hreg_phase_map u_map (
    .clk(clk), .rst_n(rst_int_n), .active(active), .slot(slot),
    .mir_lat(mir_lat), .ph(ph)
  );

  assign ph1      = ph[0];
  assign ph2      = ph[1];
  assign ph3      = ph[2];
  assign rg_pulse = active && (slot == SLOT_LAST);
  assign pix_stb  = active && (slot == '0);
  assign pix_idx  = pix;
  assign eol      = last_cell;

  a_r6_rg_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    rg_pulse |=> !rg_pulse);
  a_r8_eol_with_rg: assert property (@(posedge clk) disable iff (!rst_int_n)
    eol |-> (rg_pulse && pix_idx == PIX_W'(CELLS - 1)));
  a_r2_stb_after_rg: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rg_pulse && line_en) |=> pix_stb);
endmodule

// File: tb/tb_hreg_clock_gen.sv
module tb_hreg_clock_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 1086;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_en = 1'b0;
  logic mirror = 1'b0;
  logic ph1, ph2, ph3, rg_pulse, pix_stb, eol;
  logic [10:0] pix_idx;

  int checks = 0;
  int failures = 0;
  int stb_cnt = 0;
  bit done = 0;

  // reference model state
  bit m_act = 0;
  int m_slot = 0;
  int m_pix = 0;
  bit m_mir = 0;
  bit cmp_en = 0;

  hreg_clock_gen dut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .mirror(mirror),
    .ph1(ph1), .ph2(ph2), .ph3(ph3), .rg_pulse(rg_pulse),
    .pix_stb(pix_stb), .pix_idx(pix_idx), .eol(eol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit wave(input int k, input int s);
    return ((s + 6 - 2*k) % 6) < 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_slot = 0; m_pix = 0; m_mir = 0;
    end else if (!line_en) begin
      m_act = 0; m_slot = 0; m_pix = 0;
    end else if (!m_act) begin
      m_act = 1; m_slot = 0; m_pix = 0; m_mir = mirror;
    end else if (m_slot == 5) begin
      m_slot = 0;
      if (m_pix == CELLS-1) begin m_pix = 0; m_mir = mirror; end
      else m_pix++;
    end else m_slot++;
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      bit w1, w2, w3, e1, e2;
      w1 = m_act ? wave(0, m_slot) : 1'b1;
      w2 = m_act ? wave(1, m_slot) : 1'b0;
      w3 = m_act ? wave(2, m_slot) : 1'b0;
      e1 = m_mir ? w2 : w1;
      e2 = m_mir ? w1 : w2;
      chk(m_mir ? "R4 ph1" : "R3 ph1", ph1, e1);
      chk(m_mir ? "R4 ph2" : "R3 ph2", ph2, e2);
      chk("R3 ph3", ph3, w3);
      chk("R5 phase count", ((ph1 + ph2 + ph3) >= 1 && (ph1 + ph2 + ph3) <= 2), 1);
      chk("R6 rg_pulse", rg_pulse, m_act && m_slot == 5);
      chk("R2 pix_stb", pix_stb, m_act && m_slot == 0);
      chk("R7 pix_idx", pix_idx, m_pix);
      chk("R8 eol", eol, m_act && m_slot == 5 && m_pix == CELLS-1);
      if (!line_en && !m_act) stb_cnt = 0;
      if (pix_stb) stb_cnt++;
      if (eol) begin
        chk("R11 strobes per line", stb_cnt, CELLS);
        stb_cnt = 0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle_check(input string req, input bit exp_mir);
    chk({req, " idle ph1"}, ph1, !exp_mir);
    chk({req, " idle ph2"}, ph2, exp_mir);
    chk({req, " idle ph3"}, ph3, 0);
    chk({req, " idle rg"}, rg_pulse, 0);
    chk({req, " idle stb"}, pix_stb, 0);
    chk({req, " idle idx"}, pix_idx, 0);
    chk({req, " idle eol"}, eol, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    idle_check("R1 in reset", 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(6);
    idle_check("R1 after reset", 0);
    cmp_en = 1;
    // normal line with mirror toggled mid-line (R10), then wrap into second line
    line_en = 1'b1;
    cyc(6 * 100 + 3);
    mirror = 1'b1;
    cyc(6 * 200);
    mirror = 1'b0;
    cyc(6 * 100);
    mirror = 1'b1;
    cyc(6 * CELLS - 6 * 400 - 3);
    // now in second line, mirrored (latched at wrap)
    cyc(6 * 50 + 2);
    line_en = 1'b0;
    cyc(1);
    @(negedge clk);
    idle_check("R9 abort", 1);
    cyc(5);
    mirror = 1'b0;
    cyc(3);
    idle_check("R10 idle keeps mirror", 1);
    line_en = 1'b1;
    cyc(6 * CELLS + 20);
    line_en = 1'b0;
    mirror = 1'b1;
    cyc(4);
    line_en = 1'b1;
    cyc(6 * CELLS + 8);
    line_en = 1'b0;
    cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule